// File: doc/BRIEF.md
# Transport Stream Dual-View Output Port

This block sits at the end of a satellite receiver's decode chain. It takes decoded transport stream bytes from an upstream valid/ready byte stream. Each byte arrives with a start-of-packet marker and an uncorrectable marker. The block presents every byte on two views at once. The first is an 8-bit parallel bus with its own output clock, enable, packet sync and uncorrectable strobe. The second is a bit-serial line with its own clock, enable, packet sync and uncorrectable flag. Both views share one byte slot, so they always carry the same byte.

Each byte occupies DATA_W serial bit periods, and each bit period lasts BIT_CYC cycles of the core clock. While the serial shifter still has unsent bits, the block holds upstream off. The final cycle of a slot accepts the next byte, so a continuous stream leaves no gap.

A separate lock output combines three upstream synchronisation indications. In normal mode it follows their AND. In interrupt mode it turns into a sticky flag. Any change of the combined condition sets the flag, and the host clears it with a clear input.

Top module: `tsout_port`

## Requirements
- R1: The cycle after a byte is accepted (in_valid and in_ready high at a rising edge), par_en goes high and par_data shows that byte, both for exactly DATA_W*BIT_CYC cycles. With no byte in the slot, par_en is low and par_data is zero.
- R2: Within each byte slot, par_clk is low during bit periods 0 to DATA_W/2-1 and high during bit periods DATA_W/2 to DATA_W-1. Outside a slot it is low.
- R3: par_sync and ser_sync are high for the whole slot of a byte accepted with in_sop=1, and low for every other byte.
- R4: in_uncor is sampled only with a byte that has in_sop=1. That value appears on par_uncor and ser_uncor for every byte of the packet. in_uncor given with any other byte has no effect.
- R5: ser_data sends the byte MSB first. Bit DATA_W-1-k is driven during cycles k*BIT_CYC to k*BIT_CYC+BIT_CYC-1 of the slot. ser_clk is low for the first BIT_CYC/2 cycles of each bit period and high for the rest.
- R6: ser_en equals par_en at all times, and ser_clk stays low whenever ser_en is low.
- R7: in_ready is high when the slot is empty and in the last cycle of a slot, and low in every other cycle of a slot. A byte offered in that last cycle starts a new slot without a gap.
- R8: With irq_mode=0, lock_o is high one cycle after sync_demod, sync_fec and sync_dil are all high, and low one cycle after any one of them is low.
- R9: With irq_mode=1, lock_o shows a sticky flag. The flag is set one cycle after the combined lock condition changes, in either direction. It holds until irq_clr is sampled high. If a change and irq_clr occur in the same cycle, the set wins.
- R10: During reset, all parallel, serial and lock outputs are low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Upstream byte valid |
| in_ready | output | 1 | Block can take a byte |
| in_data | input | DATA_W | Upstream byte |
| in_sop | input | 1 | Byte is the first of a packet |
| in_uncor | input | 1 | Packet is uncorrectable (sampled on first byte) |
| par_data | output | DATA_W | Parallel byte bus |
| par_clk | output | 1 | Parallel output clock |
| par_en | output | 1 | Parallel data enable |
| par_sync | output | 1 | Parallel packet sync |
| par_uncor | output | 1 | Parallel uncorrectable strobe |
| ser_data | output | 1 | Serial data line |
| ser_clk | output | 1 | Serial bit clock |
| ser_en | output | 1 | Serial enable |
| ser_sync | output | 1 | Serial packet sync |
| ser_uncor | output | 1 | Serial uncorrectable flag |
| sync_demod | input | 1 | Demodulator synchronised |
| sync_fec | input | 1 | Inner decoder synchronised |
| sync_dil | input | 1 | De-interleaver synchronised |
| irq_mode | input | 1 | Lock output acts as sticky interrupt |
| irq_clr | input | 1 | Clears the sticky lock interrupt |
| lock_o | output | 1 | Front-end lock or interrupt request |

## Verification
The bench builds the port with DATA_W=8 and BIT_CYC=4. A four-cycle bit period makes the low and high halves of ser_clk each two cycles long, so a half-period off-by-one shows up in the output. Every bit and every cycle of each slot is compared, which covers the point where par_clk changes at the middle of the byte. Back-to-back bytes cover the hand-over in the last slot cycle, and a second packet shows that in_uncor on a later byte is ignored.

// File: rtl/tsout_pkg.sv
package tsout_pkg;
  typedef struct packed {
    logic sop;
    logic uncor;
  } pkt_tag_t;
endpackage

// File: rtl/tsout_serializer.sv
module tsout_serializer #(
  parameter int DATA_W  = 8,
  parameter int BIT_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  output logic              busy,
  output logic              last_cyc,
  output logic              bit_out,
  output logic              bit_phase,
  output logic              byte_phase,
  output logic [DATA_W-1:0] byte_out
);
  localparam int SUB_W = $clog2(BIT_CYC);
  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(BIT_CYC - 1);
  localparam logic [SUB_W-1:0] SUB_HALF = SUB_W'(BIT_CYC / 2);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_W - 1);
  localparam logic [IDX_W-1:0] IDX_HALF = IDX_W'(DATA_W / 2);

  logic              busy_q, busy_d;
  logic [SUB_W-1:0]  sub_q, sub_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [DATA_W-1:0] shf_q, shf_d;
  logic [DATA_W-1:0] byte_q, byte_d;

  always_comb begin
    busy_d = busy_q;
    sub_d  = sub_q;
    idx_d  = idx_q;
    shf_d  = shf_q;
    byte_d = byte_q;
    if (load) begin
      busy_d = 1'b1;
      sub_d  = '0;
      idx_d  = '0;
      shf_d  = load_data;
      byte_d = load_data;
    end else if (busy_q) begin
      if (sub_q == SUB_LAST) begin
        sub_d = '0;
        shf_d = {shf_q[DATA_W-2:0], 1'b0};
        if (idx_q == IDX_LAST) busy_d = 1'b0;
        else                   idx_d  = idx_q + IDX_W'(1);
      end else begin
        sub_d = sub_q + SUB_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sub_q  <= '0;
      idx_q  <= '0;
      shf_q  <= '0;
      byte_q <= '0;
    end else begin
      busy_q <= busy_d;
      sub_q  <= sub_d;
      idx_q  <= idx_d;
      shf_q  <= shf_d;
      byte_q <= byte_d;
    end
  end

  assign busy       = busy_q;
  assign last_cyc   = busy_q && (idx_q == IDX_LAST) && (sub_q == SUB_LAST);
  assign bit_out    = busy_q & shf_q[DATA_W-1];
  assign bit_phase  = busy_q && (sub_q >= SUB_HALF);
  assign byte_phase = busy_q && (idx_q >= IDX_HALF);
  assign byte_out   = busy_q ? byte_q : '0;
endmodule

// File: rtl/tsout_tagger.sv
module tsout_tagger
  import tsout_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     load,
  input  logic     sop_in,
  input  logic     uncor_in,
  output pkt_tag_t tag
);
  pkt_tag_t tag_q, tag_d;

  always_comb begin
    tag_d = tag_q;
    if (load) begin
      tag_d.sop = sop_in;
      if (sop_in) tag_d.uncor = uncor_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tag_q <= '0;
    else        tag_q <= tag_d;
  end

  assign tag = tag_q;
endmodule

// File: rtl/tsout_lock.sv
module tsout_lock (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_a,
  input  logic sync_b,
  input  logic sync_c,
  input  logic irq_mode,
  input  logic irq_clr,
  output logic lock_o
);
  logic cond, cond_q, irq_q, irq_d;

  assign cond = sync_a & sync_b & sync_c;

  always_comb begin
    irq_d = irq_q;
    if (cond != cond_q) irq_d = 1'b1;
    else if (irq_clr)   irq_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cond_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      cond_q <= cond;
      irq_q  <= irq_d;
    end
  end

  assign lock_o = irq_mode ? irq_q : cond_q;
endmodule

// File: rtl/tsout_port.sv
module tsout_port
  import tsout_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int BIT_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_sop,
  input  logic              in_uncor,
  output logic [DATA_W-1:0] par_data,
  output logic              par_clk,
  output logic              par_en,
  output logic              par_sync,
  output logic              par_uncor,
  output logic              ser_data,
  output logic              ser_clk,
  output logic              ser_en,
  output logic              ser_sync,
  output logic              ser_uncor,
  input  logic              sync_demod,
  input  logic              sync_fec,
  input  logic              sync_dil,
  input  logic              irq_mode,
  input  logic              irq_clr,
  output logic              lock_o
);
  logic     busy, last_cyc, accept, bit_out, bit_phase, byte_phase;
  pkt_tag_t tag;

  assign in_ready = ~busy | last_cyc;
  assign accept   = in_valid & in_ready;

  tsout_serializer #(.DATA_W(DATA_W), .BIT_CYC(BIT_CYC)) u_ser (
    .clk(clk), .rst_n(rst_n), .load(accept), .load_data(in_data),
    .busy(busy), .last_cyc(last_cyc), .bit_out(bit_out),
    .bit_phase(bit_phase), .byte_phase(byte_phase), .byte_out(par_data)
  );

  tsout_tagger u_tag (
    .clk(clk), .rst_n(rst_n), .load(accept),
    .sop_in(in_sop), .uncor_in(in_uncor), .tag(tag)
  );

  tsout_lock u_lock (
    .clk(clk), .rst_n(rst_n), .sync_a(sync_demod), .sync_b(sync_fec),
    .sync_c(sync_dil), .irq_mode(irq_mode), .irq_clr(irq_clr), .lock_o(lock_o)
  );

  assign par_en    = busy;
  assign par_clk   = byte_phase;
  assign par_sync  = busy & tag.sop;
  assign par_uncor = busy & tag.uncor;
  assign ser_en    = busy;
  assign ser_clk   = bit_phase;
  assign ser_data  = bit_out;
  assign ser_sync  = busy & tag.sop;
  assign ser_uncor = busy & tag.uncor;
endmodule

// File: rtl/tsout_port_chk.sv
module tsout_port_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_ready,
  input logic [DATA_W-1:0] par_data,
  input logic              par_en,
  input logic              par_sync,
  input logic              par_uncor,
  input logic              ser_en,
  input logic              ser_clk,
  input logic              ser_sync,
  input logic              ser_uncor,
  input logic              sync_demod,
  input logic              sync_fec,
  input logic              sync_dil,
  input logic              irq_mode,
  input logic              irq_clr,
  input logic              lock_o
);
  // R6
  en_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ser_en == par_en);
  // R6
  sclk_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_en |-> !ser_clk);
  // R3
  sync_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    par_sync |-> (ser_sync && par_en));
  // R4
  uncor_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    par_uncor == ser_uncor);
  // R7
  hold_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (par_en && !in_ready) |=> (par_en && $stable(par_data)));
  // R8
  lock_norm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_mode && sync_demod && sync_fec && sync_dil) |=> (irq_mode || lock_o));
  // R9
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_mode && lock_o && !irq_clr) |=> (!irq_mode || lock_o));
endmodule

bind tsout_port tsout_port_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .par_data(par_data),
  .par_en(par_en), .par_sync(par_sync), .par_uncor(par_uncor),
  .ser_en(ser_en), .ser_clk(ser_clk), .ser_sync(ser_sync),
  .ser_uncor(ser_uncor), .sync_demod(sync_demod), .sync_fec(sync_fec),
  .sync_dil(sync_dil), .irq_mode(irq_mode), .irq_clr(irq_clr), .lock_o(lock_o)
);

// File: tb/tsout_port_tb.sv
module tsout_port_tb;
  localparam int PERIOD = 10;
  localparam int BC     = 4;
  localparam int NB     = 8 * BC;

  logic clk, rst_n, in_valid, in_ready, in_sop, in_uncor;
  logic [7:0] in_data, par_data;
  logic par_clk, par_en, par_sync, par_uncor;
  logic ser_data, ser_clk, ser_en, ser_sync, ser_uncor;
  logic sync_demod, sync_fec, sync_dil, irq_mode, irq_clr, lock_o;
  int vec_n, err_n;

  tsout_port #(.DATA_W(8), .BIT_CYC(BC)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sop(in_sop), .in_uncor(in_uncor),
    .par_data(par_data), .par_clk(par_clk), .par_en(par_en),
    .par_sync(par_sync), .par_uncor(par_uncor), .ser_data(ser_data),
    .ser_clk(ser_clk), .ser_en(ser_en), .ser_sync(ser_sync),
    .ser_uncor(ser_uncor), .sync_demod(sync_demod), .sync_fec(sync_fec),
    .sync_dil(sync_dil), .irq_mode(irq_mode), .irq_clr(irq_clr), .lock_o(lock_o)
  );

  initial clk = 1'b0;
  always #(PERIOD / 2) clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    vec_n++;
    if (act !== exp) begin
      err_n++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Presents one byte at the current negedge and checks every cycle of its slot.
  task automatic xfer(input logic [7:0] d, input logic s, input logic u, input logic eu);
    in_data = d; in_sop = s; in_uncor = u; in_valid = 1'b1;
    chk("R7 ready before accept", {7'b0, in_ready}, 8'd1);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0; in_data = 8'h00; in_sop = 1'b0; in_uncor = 1'b0;
    for (int c = 0; c < NB; c++) begin
      int b;
      int sb;
      b  = c / BC;
      sb = c % BC;
      chk("R1 par_en", {7'b0, par_en}, 8'd1);
      chk("R1 par_data", par_data, d);
      chk("R2 par_clk", {7'b0, par_clk}, {7'b0, b >= 4});
      chk("R3 par_sync", {7'b0, par_sync}, {7'b0, s});
      chk("R3 ser_sync", {7'b0, ser_sync}, {7'b0, s});
      chk("R4 par_uncor", {7'b0, par_uncor}, {7'b0, eu});
      chk("R4 ser_uncor", {7'b0, ser_uncor}, {7'b0, eu});
      chk("R5 ser_data", {7'b0, ser_data}, {7'b0, d[7-b]});
      chk("R5 ser_clk", {7'b0, ser_clk}, {7'b0, sb >= BC / 2});
      chk("R6 ser_en", {7'b0, ser_en}, 8'd1);
      chk("R7 ready in slot", {7'b0, in_ready}, {7'b0, c == NB - 1});
      if (c < NB - 1) @(negedge clk);
    end
  endtask

  task automatic check_idle(input string tag);
    @(negedge clk);
    chk({tag, " R1 par_en idle"}, {7'b0, par_en}, 8'd0);
    chk({tag, " R1 par_data idle"}, par_data, 8'd0);
    chk({tag, " R6 ser_en idle"}, {7'b0, ser_en}, 8'd0);
    chk({tag, " R6 ser_clk idle"}, {7'b0, ser_clk}, 8'd0);
    chk({tag, " R2 par_clk idle"}, {7'b0, par_clk}, 8'd0);
    chk({tag, " R7 ready idle"}, {7'b0, in_ready}, 8'd1);
  endtask

  task automatic test_reset;
    rst_n = 1'b0;
    in_valid = 0; in_data = 0; in_sop = 0; in_uncor = 0;
    sync_demod = 0; sync_fec = 0; sync_dil = 0; irq_mode = 0; irq_clr = 0;
    @(negedge clk);
    @(negedge clk);
    chk("R10 par_en", {7'b0, par_en}, 8'd0);
    chk("R10 par_data", par_data, 8'd0);
    chk("R10 par_clk", {7'b0, par_clk}, 8'd0);
    chk("R10 par_sync", {7'b0, par_sync}, 8'd0);
    chk("R10 par_uncor", {7'b0, par_uncor}, 8'd0);
    chk("R10 ser_data", {7'b0, ser_data}, 8'd0);
    chk("R10 ser_clk", {7'b0, ser_clk}, 8'd0);
    chk("R10 ser_en", {7'b0, ser_en}, 8'd0);
    chk("R10 ser_sync", {7'b0, ser_sync}, 8'd0);
    chk("R10 ser_uncor", {7'b0, ser_uncor}, 8'd0);
    chk("R10 lock_o", {7'b0, lock_o}, 8'd0);
    chk("R10 in_ready", {7'b0, in_ready}, 8'd1);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic test_stream;
    // bad packet: flag latched on first byte, held on second (R4)
    xfer(8'hA5, 1'b1, 1'b1, 1'b1);
    xfer(8'h3C, 1'b0, 1'b0, 1'b1);
    check_idle("gap1");
    // good packet: in_uncor on a later byte is ignored (R4)
    xfer(8'h47, 1'b1, 1'b0, 1'b0);
    xfer(8'h81, 1'b0, 1'b1, 1'b0);
    xfer(8'h5E, 1'b0, 1'b0, 1'b0);
    check_idle("gap2");
  endtask

  task automatic set_sync(input logic a, input logic b, input logic c);
    sync_demod = a; sync_fec = b; sync_dil = c;
    @(negedge clk);
  endtask

  task automatic test_lock_normal;
    irq_mode = 1'b0;
    set_sync(1, 1, 1);
    chk("R8 all synced", {7'b0, lock_o}, 8'd1);
    set_sync(0, 1, 1);
    chk("R8 demod lost", {7'b0, lock_o}, 8'd0);
    set_sync(1, 0, 1);
    chk("R8 fec lost", {7'b0, lock_o}, 8'd0);
    set_sync(1, 1, 0);
    chk("R8 dil lost", {7'b0, lock_o}, 8'd0);
    set_sync(1, 1, 1);
    chk("R8 relock", {7'b0, lock_o}, 8'd1);
  endtask

  task automatic test_lock_irq;
    irq_mode = 1'b1; irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
    chk("R9 cleared", {7'b0, lock_o}, 8'd0);
    @(negedge clk);
    chk("R9 no change stays low", {7'b0, lock_o}, 8'd0);
    set_sync(1, 1, 0);
    chk("R9 set on loss", {7'b0, lock_o}, 8'd1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R9 sticky", {7'b0, lock_o}, 8'd1);
    end
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
    chk("R9 host clear", {7'b0, lock_o}, 8'd0);
    irq_clr = 1'b1;
    set_sync(1, 1, 1);
    irq_clr = 1'b0;
    chk("R9 set wins over clear", {7'b0, lock_o}, 8'd1);
    irq_mode = 1'b0;
    @(negedge clk);
    chk("R8 back to normal", {7'b0, lock_o}, 8'd1);
  endtask

  initial begin
    vec_n = 0; err_n = 0;
    test_reset();
    test_stream();
    test_lock_normal();
    test_lock_irq();
    $display("== %0d vectors applied, %0d miscompares ==", vec_n, err_n);
    $finish;
  end

  initial begin
    #(PERIOD * 200000);
    err_n++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vec_n, err_n);
    $finish;
  end
endmodule